// File: doc/BRIEF.md
# Cross-Domain Audio Slot Enable Register

This block is a host-side control register that holds one enable bit for each slot of an audio serial link: four transmit slots and one receive slot. Software enables slots with write-one-to-set writes. A zero in a written bit leaves that bit as it was. Clearing an enable is the job of a separate register and is not part of this block.

The host bus and the serial link run on unrelated clocks. Each accepted write updates the host-side copy at once. The new word is then carried to the bit-clock domain with a toggle request/acknowledge handshake, and each direction of that handshake passes through a two-flop synchronizer. While a transfer is in flight, a read-only pending flag in the top bit of the read word is set, and further writes are dropped. If the bit clock stops, the flag stays set. Software can read this as a sign that the link clock is dead.

Both the host copy and the bit-clock-side enable vector come out of reset at the reset value. By default every slot is enabled, so the link works from reset without any handshake.

Top module: `slot_en_reg`

## Requirements
- R1: Enable bit positions: bit 0 = PCM left/right transmit, bit 1 = surround left/right transmit, bit 2 = center transmit, bit 3 = LFE transmit, bit 4 = audio receive. These positions are the same in the host read word and in `slotEnable`.
- R2: After host reset, the enable field in `rdData[4:0]` equals parameter `RESET_ENABLES`, and that parameter defaults to all ones.
- R3: A write accepted while nothing is pending ORs `wrData[4:0]` into the enable field. A 0 in a written bit never clears an enable.
- R4: `rdData` is a combinational read. Bits [4:0] hold the host copy of the enables, bits [30:5] read 0, and bit 31 is the pending flag.
- R5: An accepted write sets `rdData[31]` on the next host clock. The flag stays set until the bit-clock side has applied the word and its acknowledge has come back.
- R6: `slotEnable` takes the written word no earlier than the third bit-clock edge after the request toggles. When pending clears, `slotEnable` equals the host copy.
- R7: While `bitClk` is stopped, a pending write keeps `rdData[31]` set indefinitely and `slotEnable` unchanged. Once the clock resumes, the transfer completes.
- R8: A write issued while `rdData[31]` is 1 is ignored. The host copy, the transferred word and `slotEnable` all stay as they were.
- R9: Bit 31 is read-only. Writing 1 to it, or to any bit in [30:5], changes no enable.
- R10: After bit-side reset, `slotEnable` equals `RESET_ENABLES` without any handshake.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| hostClk | input | 1 | Host bus clock |
| hostRstN | input | 1 | Active-low host-domain reset |
| wrEn | input | 1 | Write strobe, one host cycle |
| wrData | input | 32 | Write data; bits set to 1 enable slots |
| rdData | output | 32 | Read word: enables [4:0], pending flag [31] |
| bitClk | input | 1 | Serial link bit clock |
| bitRstN | input | 1 | Active-low bit-clock-domain reset |
| slotEnable | output | 5 | Enable vector in the bit-clock domain |

## Verification
The write-one-to-set path is driven with the following patterns:
- Sparse bit patterns onto an empty field, which shows that each written bit lands at its own position.
- Patterns that hold zeros over bits already set, which separates OR-merging from plain overwrite.
- A back-to-back pair of writes, which separates drop-while-pending from last-write-wins.
- A write to only the upper bits, which shows the pending flag and the unused field cannot be written.
- A write issued with the bit clock stopped, which shows that pending really waits for the far-side acknowledge and not for a fixed delay.

A second instance left at its defaults confirms the all-ones reset value on both sides.

// File: rtl/slot_en_pkg.sv
package slot_en_pkg;
  // Strobes from host-side control to the datapath
  typedef struct packed {
    logic loadWord;   // accept write: merge into host copy and capture transfer word
  } hostStrobes_t;
endpackage

// File: rtl/slot_en_sync2.sv
module slot_en_sync2 (
  input  logic clk,
  input  logic rstN,
  input  logic d,
  output logic q
);
  logic stage1;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stage1 <= 1'b0;
      q      <= 1'b0;
    end else begin
      stage1 <= d;
      q      <= stage1;
    end
  end
endmodule

// File: rtl/slot_en_ctrl.sv
module slot_en_ctrl
  import slot_en_pkg::*;
(
  input  logic         hostClk,
  input  logic         hostRstN,
  input  logic         wrEn,
  input  logic         ackTog,
  output logic         reqTog,
  output logic         pending,
  output hostStrobes_t strb
);
  logic ackSyncd;

  slot_en_sync2 u_ackSync (
    .clk (hostClk),
    .rstN(hostRstN),
    .d   (ackTog),
    .q   (ackSyncd)
  );

  // Request outstanding until the synchronized acknowledge matches it
  assign pending       = reqTog ^ ackSyncd;
  assign strb.loadWord = wrEn & ~pending;

  always_ff @(posedge hostClk or negedge hostRstN) begin
    if (!hostRstN) reqTog <= 1'b0;
    else if (strb.loadWord) reqTog <= ~reqTog;
  end
endmodule

// File: rtl/slot_en_dpath.sv
module slot_en_dpath
  import slot_en_pkg::*;
#(
  parameter int unsigned NUM_SLOTS = 5,
  parameter logic [NUM_SLOTS-1:0] RESET_ENABLES = '1
) (
  input  logic                 hostClk,
  input  logic                 hostRstN,
  input  hostStrobes_t         strb,
  input  logic [NUM_SLOTS-1:0] wrBits,
  output logic [NUM_SLOTS-1:0] shadow,
  output logic [NUM_SLOTS-1:0] xferWord
);
  logic [NUM_SLOTS-1:0] mergedWord;

  // Per-bit set-only merge
  for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_merge
    assign mergedWord[i] = shadow[i] | wrBits[i];
  end

  always_ff @(posedge hostClk or negedge hostRstN) begin
    if (!hostRstN) begin
      shadow   <= RESET_ENABLES;
      xferWord <= RESET_ENABLES;
    end else if (strb.loadWord) begin
      shadow   <= mergedWord;
      xferWord <= mergedWord;  // held until the next accepted write
    end
  end
endmodule

// File: rtl/slot_en_bitside.sv
module slot_en_bitside #(
  parameter int unsigned NUM_SLOTS = 5,
  parameter logic [NUM_SLOTS-1:0] RESET_ENABLES = '1
) (
  input  logic                 bitClk,
  input  logic                 bitRstN,
  input  logic                 reqTog,
  input  logic [NUM_SLOTS-1:0] xferWord,
  output logic                 ackTog,
  output logic [NUM_SLOTS-1:0] slotEnable
);
  logic reqSyncd;
  logic reqSeen;

  slot_en_sync2 u_reqSync (
    .clk (bitClk),
    .rstN(bitRstN),
    .d   (reqTog),
    .q   (reqSyncd)
  );

  assign ackTog = reqSeen;

  always_ff @(posedge bitClk or negedge bitRstN) begin
    if (!bitRstN) begin
      reqSeen    <= 1'b0;
      slotEnable <= RESET_ENABLES;
    end else if (reqSyncd != reqSeen) begin
      reqSeen    <= reqSyncd;
      slotEnable <= xferWord;  // stable while request outstanding
    end
  end
endmodule

// File: rtl/slot_en_reg.sv
module slot_en_reg #(
  parameter int unsigned NUM_SLOTS = 5,
  parameter int unsigned REG_W = 32,
  parameter logic [NUM_SLOTS-1:0] RESET_ENABLES = '1
) (
  input  logic                 hostClk,
  input  logic                 hostRstN,
  input  logic                 wrEn,
  input  logic [REG_W-1:0]     wrData,
  output logic [REG_W-1:0]     rdData,
  input  logic                 bitClk,
  input  logic                 bitRstN,
  output logic [NUM_SLOTS-1:0] slotEnable
);
  import slot_en_pkg::*;

  localparam int unsigned PAD_W = REG_W - 1 - NUM_SLOTS;

  hostStrobes_t         strb;
  logic                 reqTog;
  logic                 ackTog;
  logic                 pending;
  logic [NUM_SLOTS-1:0] shadow;
  logic [NUM_SLOTS-1:0] xferWord;
  logic [REG_W-1:NUM_SLOTS] unusedWrBits;

  assign unusedWrBits = wrData[REG_W-1:NUM_SLOTS];

  slot_en_ctrl u_ctrl (
    .hostClk (hostClk),
    .hostRstN(hostRstN),
    .wrEn    (wrEn),
    .ackTog  (ackTog),
    .reqTog  (reqTog),
    .pending (pending),
    .strb    (strb)
  );

  slot_en_dpath #(
    .NUM_SLOTS    (NUM_SLOTS),
    .RESET_ENABLES(RESET_ENABLES)
  ) u_dpath (
    .hostClk (hostClk),
    .hostRstN(hostRstN),
    .strb    (strb),
    .wrBits  (wrData[NUM_SLOTS-1:0]),
    .shadow  (shadow),
    .xferWord(xferWord)
  );

  slot_en_bitside #(
    .NUM_SLOTS    (NUM_SLOTS),
    .RESET_ENABLES(RESET_ENABLES)
  ) u_bitside (
    .bitClk    (bitClk),
    .bitRstN   (bitRstN),
    .reqTog    (reqTog),
    .xferWord  (xferWord),
    .ackTog    (ackTog),
    .slotEnable(slotEnable)
  );

  assign rdData = {pending, {PAD_W{1'b0}}, shadow};
endmodule

// File: rtl/slot_en_reg_chk.sv
module slot_en_reg_chk #(
  parameter int unsigned NUM_SLOTS = 5,
  parameter int unsigned REG_W = 32
) (
  input logic                 hostClk,
  input logic                 hostRstN,
  input logic                 wrEn,
  input logic [REG_W-1:0]     wrData,
  input logic [REG_W-1:0]     rdData,
  input logic                 bitClk,
  input logic                 bitRstN,
  input logic [NUM_SLOTS-1:0] slotEnable,
  input logic                 pending,
  input logic [NUM_SLOTS-1:0] xferWord
);
  // R3
  w1s_merge_chk: assert property (@(posedge hostClk) disable iff (!hostRstN)
    (wrEn && !rdData[REG_W-1]) |=>
      (rdData[NUM_SLOTS-1:0] == ($past(rdData[NUM_SLOTS-1:0]) | $past(wrData[NUM_SLOTS-1:0]))));

  // R5
  pending_rise_chk: assert property (@(posedge hostClk) disable iff (!hostRstN)
    (wrEn && !rdData[REG_W-1]) |=> rdData[REG_W-1]);

  // R8
  drop_while_pending_chk: assert property (@(posedge hostClk) disable iff (!hostRstN)
    (wrEn && rdData[REG_W-1]) |=> $stable(rdData[NUM_SLOTS-1:0]));

  // R8
  held_word_chk: assert property (@(posedge hostClk) disable iff (!hostRstN)
    pending |=> $stable(xferWord));

  // R3
  bit_side_set_only_chk: assert property (@(posedge bitClk) disable iff (!bitRstN)
    ((slotEnable & $past(slotEnable)) == $past(slotEnable)));

  // R4
  pad_zero_chk: assert property (@(posedge hostClk) disable iff (!hostRstN)
    (rdData[REG_W-2:NUM_SLOTS] == '0));
endmodule

bind slot_en_reg slot_en_reg_chk #(.NUM_SLOTS(NUM_SLOTS), .REG_W(REG_W)) u_chk (
  .hostClk   (hostClk),
  .hostRstN  (hostRstN),
  .wrEn      (wrEn),
  .wrData    (wrData),
  .rdData    (rdData),
  .bitClk    (bitClk),
  .bitRstN   (bitRstN),
  .slotEnable(slotEnable),
  .pending   (pending),
  .xferWord  (xferWord)
);

// File: tb/slot_en_reg_tb.sv
`timescale 1ns/100ps
module slot_en_reg_tb;
  logic        hostClk = 1'b0;
  logic        bitClk  = 1'b0;
  logic        bitRun  = 1'b1;
  logic        hostRstN = 1'b0;
  logic        bitRstN  = 1'b0;
  logic        wrEn = 1'b0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData, rdDataDef;
  logic [4:0]  slotEnable, slotEnableDef;
  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  logic [4:0] expEn;

  always #2.5 hostClk = ~hostClk;              // 200 MHz
  always begin
    #13;
    if (bitRun) bitClk = ~bitClk;
  end

  slot_en_reg #(.RESET_ENABLES(5'b00000)) u_dut (
    .hostClk(hostClk), .hostRstN(hostRstN), .wrEn(wrEn), .wrData(wrData),
    .rdData(rdData), .bitClk(bitClk), .bitRstN(bitRstN), .slotEnable(slotEnable)
  );

  slot_en_reg u_dutDef (
    .hostClk(hostClk), .hostRstN(hostRstN), .wrEn(1'b0), .wrData(32'h0),
    .rdData(rdDataDef), .bitClk(bitClk), .bitRstN(bitRstN), .slotEnable(slotEnableDef)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic doWrite(input logic [31:0] d);
    @(negedge hostClk);
    wrEn = 1'b1; wrData = d;
    @(negedge hostClk);
    wrEn = 1'b0; wrData = '0;
  endtask

  task automatic waitClear(input string req);
    int n = 0;
    while (rdData[31] && n < 2000) begin
      @(negedge hostClk);
      n++;
    end
    check(req, {31'b0, rdData[31]}, 32'h0);
  endtask

  task automatic t_reset;
    check("R2", rdDataDef, 32'h0000_001F);
    check("R10", {27'b0, slotEnableDef}, 32'h1F);
    check("R4", rdData, 32'h0);
    check("R10", {27'b0, slotEnable}, 32'h0);
  endtask

  task automatic t_basicSet;
    doWrite(32'h0000_0005);
    expEn = 5'h05;
    check("R5", {31'b0, rdData[31]}, 32'h1);
    check("R4", rdData, 32'h8000_0005);
    check("R6", {27'b0, slotEnable}, 32'h0);
    waitClear("R5");
    check("R6", {27'b0, slotEnable}, {27'b0, expEn});
    check("R1", {31'b0, slotEnable[0]}, 32'h1);  // PCM transmit
    check("R1", {31'b0, slotEnable[2]}, 32'h1);  // center transmit
  endtask

  task automatic t_zeroNoClear;
    doWrite(32'h0000_0002);
    expEn = expEn | 5'h02;
    waitClear("R5");
    check("R3", rdData, {27'b0, expEn});
    check("R3", {27'b0, slotEnable}, {27'b0, expEn});
  endtask

  task automatic t_dropWhilePending;
    @(negedge hostClk);
    wrEn = 1'b1; wrData = 32'h0000_0008;
    @(negedge hostClk);
    wrData = 32'h0000_0010;                    // arrives while pending
    @(negedge hostClk);
    wrEn = 1'b0; wrData = '0;
    expEn = expEn | 5'h08;
    check("R8", rdData, {1'b1, 26'b0, expEn});
    waitClear("R8");
    check("R8", rdData, {27'b0, expEn});
    check("R8", {27'b0, slotEnable}, {27'b0, expEn});
    check("R1", {31'b0, slotEnable[3]}, 32'h1);  // LFE transmit
  endtask

  task automatic t_pendingReadOnly;
    doWrite(32'hFFFF_FFE0);
    waitClear("R9");
    check("R9", rdData, {27'b0, expEn});
    check("R9", {27'b0, slotEnable}, {27'b0, expEn});
  endtask

  task automatic t_bitClkStopped;
    @(negedge bitClk);
    bitRun = 1'b0;
    doWrite(32'h0000_0010);
    repeat (300) @(negedge hostClk);
    check("R7", {31'b0, rdData[31]}, 32'h1);
    check("R7", {27'b0, slotEnable}, {27'b0, expEn});
    bitRun = 1'b1;
    expEn = expEn | 5'h10;
    waitClear("R7");
    check("R7", {27'b0, slotEnable}, {27'b0, expEn});
    check("R1", {31'b0, slotEnable[4]}, 32'h1);  // audio receive
  endtask

  task automatic finishRun;
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #500_000;
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    repeat (4) @(negedge bitClk);
    hostRstN = 1'b1;
    bitRstN  = 1'b1;
    repeat (2) @(negedge hostClk);
    t_reset();
    t_basicSet();
    t_zeroNoClear();
    t_dropWhilePending();
    t_pendingReadOnly();
    t_bitClkStopped();
    finishRun();
  end
endmodule